// File: doc/BRIEF.md
# MDIO Management Master with Register Control

This block drives the two-wire management bus of Ethernet PHYs. Software programs a clock divider, sets a management enable bit, and then writes one complete 32-bit frame word into the data register. That write launches the serial transaction. The block produces MDC from the system clock and sends 32 preamble ones, followed by the frame word MSB first, on a tri-stated MDIO line. For a read it hands MDIO over to the PHY from the turnaround bits onward and collects the 16 returned bits. When the frame ends, a sticky event flag goes high. Software clears it by writing a 1.

The sequencer has three states. In IDLE, MDC is low and MDIO is not driven. An accepted data-register write moves IDLE to PREAMBLE. PREAMBLE moves to FRAME on the MDC falling edge that ends the 32nd preamble bit. FRAME moves back to IDLE on the falling edge that ends the 32nd frame bit. That last edge also sets the event flag.

Register map (word address on `reg_addr`):
- 0 is control, with bit 0 as the management enable.
- 1 is speed, with the divider in bits [6:1].
- 2 is the frame/data register.
- 3 is event. Bit 0 is the completion flag (write 1 to clear). Bit 1 is the read-only busy status.

All unlisted bits read as 0.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, mdc, mdio_oe and mgmt_evt are 0, and all four registers read as 0.
- R2: A write to address 2, made while the enable bit is 1 and the divider is nonzero, starts a transaction. MDIO then carries 32 ones followed by the written word, bit 31 first, and each bit is valid at an MDC rising edge.
- R3: The divider is speed-register bits [6:1]; bit 0 and bits above 6 have no effect. Every MDC high and low phase lasts exactly that many system clocks.
- R4: While the divider is 0, MDC stays low and a data write starts no transaction.
- R5: While control bit 0 is 0, a data write starts nothing and leaves the data register unchanged.
- R6: mdio_o and mdio_oe change only while MDC is low, and never in a cycle in which MDC is high.
- R7: If frame bits [29:28] are 10 (read), mdio_oe is 0 from frame bit 17 through the end. The 16 bits sampled on the MDC rising edges of frame bits 15..0 replace data-register bits [15:0], and bits [31:16] keep the written word.
- R8: At the end of every transaction, event bit 0 and mgmt_evt become 1. Writing 1 to event bit 0 clears it, and writing 0 leaves it set.
- R9: Event bit 1 (busy) is 1 from the cycle after the starting write until the cycle the event flag sets. A data write during that window is ignored: the frame and the data register keep the first word.
- R10: For a write opcode (any code other than 10), mdio_oe stays 1 for all 64 bits, and it is 0 whenever no transaction runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |
| mgmt_evt | output | 1 | Completion event flag |

## Verification
The hardest case to reach from the ports is a second data write that lands in the middle of a running frame. The bench reaches it by forking two threads. One thread follows MDC and records every bit of the frame. The other fires the second write partway through the preamble, then reads busy and the data register while the frame is still running. Read frames also need a PHY that answers in step with MDC. The bench models this by driving mdio_i right after each MDC fall during the data phase, so every bit is stable at the next rising edge. It does this even with a one-clock divider.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PREAMBLE = 2'd1,
        ST_FRAME    = 2'd2
    } mdio_state_e;

    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_SPEED = 2'd1;
    localparam logic [1:0] A_DATA  = 2'd2;
    localparam logic [1:0] A_EVENT = 2'd3;

    localparam logic [1:0] OP_READ = 2'b10;
    localparam int FRAME_BITS = 32;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             active;
    logic             terminal;

    assign active    = run && (div != '0);
    assign terminal  = active && (cnt_q == div - DIV_W'(1));
    assign rise_tick = terminal && !mdc_q;
    assign fall_tick = terminal && mdc_q;
    assign mdc       = mdc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!active) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (terminal) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R4
    zero_div_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |=> !mdc);

    // R3
    tick_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc != $past(mdc)) |-> $past(active));
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int PRE_BITS  = 32,
    parameter int DATA_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [31:0]          frame_word,
    input  logic                 rise_tick,
    input  logic                 fall_tick,
    input  logic                 mdc,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 done,
    output logic                 is_read,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic [DATA_BITS-1:0] rd_data
);
    localparam int MAX_BITS = (PRE_BITS > FRAME_BITS) ? PRE_BITS : FRAME_BITS;
    localparam int CNT_W    = $clog2(MAX_BITS);
    localparam int TA_POS   = FRAME_BITS - DATA_BITS - 2;
    localparam int DATA_POS = FRAME_BITS - DATA_BITS;

    mdio_state_e          state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [31:0]          sh_q;
    logic                 rd_q;
    logic [DATA_BITS-1:0] cap_q;
    logic                 o_q, oe_q;
    logic                 pre_last, frm_last;

    assign pre_last = (cnt_q == CNT_W'(PRE_BITS - 1));
    assign frm_last = (cnt_q == CNT_W'(FRAME_BITS - 1));
    assign done     = (state_q == ST_FRAME) && fall_tick && frm_last;
    assign busy     = (state_q != ST_IDLE);
    assign is_read  = rd_q;
    assign mdio_o   = o_q;
    assign mdio_oe  = oe_q;
    assign rd_data  = cap_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_tick && pre_last) state_d = ST_FRAME;
            ST_FRAME:    if (fall_tick && frm_last) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
            rd_q  <= 1'b0;
            cap_q <= '0;
            o_q   <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        sh_q  <= frame_word;
                        rd_q  <= (frame_word[29:28] == OP_READ);
                        cnt_q <= '0;
                        cap_q <= '0;
                        o_q   <= 1'b1;
                        oe_q  <= 1'b1;
                    end
                end
                ST_PREAMBLE: begin
                    if (fall_tick) begin
                        if (pre_last) begin
                            cnt_q <= '0;
                            o_q   <= sh_q[31];
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_FRAME: begin
                    if (fall_tick) begin
                        if (frm_last) begin
                            o_q  <= 1'b0;
                            oe_q <= 1'b0;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                            o_q   <= sh_q[30];
                            sh_q  <= {sh_q[30:0], 1'b0};
                            if (rd_q && (cnt_q == CNT_W'(TA_POS - 1)))
                                oe_q <= 1'b0;
                        end
                    end
                    if (rise_tick && rd_q && (cnt_q >= CNT_W'(DATA_POS)))
                        cap_q <= {cap_q[DATA_BITS-2:0], mdio_i};
                end
                default: ;
            endcase
        end
    end

    // R6
    mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FRAME) && rd_q && (cnt_q >= CNT_W'(TA_POS))) |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 6,
    parameter int PRE_BITS  = 32,
    parameter int DATA_BITS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i,
    output logic        mgmt_evt
);
    localparam int SPD_PAD = 32 - DIV_W - 1;

    logic                 en_q;
    logic [DIV_W-1:0]     div_q;
    logic [31:0]          data_q;
    logic                 evt_q;
    logic                 eng_busy, eng_done, eng_read;
    logic                 rise_tick, fall_tick;
    logic [DATA_BITS-1:0] eng_rd;
    logic                 data_hit, start;

    assign data_hit = reg_wr && (reg_addr == A_DATA);
    assign start    = data_hit && en_q && (div_q != '0) && !eng_busy;
    assign mgmt_evt = evt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            div_q  <= '0;
            data_q <= '0;
            evt_q  <= 1'b0;
        end else begin
            if (reg_wr && (reg_addr == A_CTRL))  en_q  <= reg_wdata[0];
            if (reg_wr && (reg_addr == A_SPEED)) div_q <= reg_wdata[DIV_W:1];
            if (start) data_q <= reg_wdata;
            else if (eng_done && eng_read) data_q[DATA_BITS-1:0] <= eng_rd;
            if (eng_done) evt_q <= 1'b1;
            else if (reg_wr && (reg_addr == A_EVENT) && reg_wdata[0]) evt_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = {31'b0, en_q};
            A_SPEED: reg_rdata = {{SPD_PAD{1'b0}}, div_q, 1'b0};
            A_DATA:  reg_rdata = data_q;
            A_EVENT: reg_rdata = {30'b0, eng_busy, evt_q};
            default: reg_rdata = '0;
        endcase
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (eng_busy),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_engine #(.PRE_BITS(PRE_BITS), .DATA_BITS(DATA_BITS)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .frame_word (reg_wdata),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .mdc        (mdc),
        .mdio_i     (mdio_i),
        .busy       (eng_busy),
        .done       (eng_done),
        .is_read    (eng_read),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .rd_data    (eng_rd)
    );

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> eng_busy);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && data_hit && !eng_done) |=> $stable(data_q));

    // R8
    evt_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_q) |-> ($past(eng_busy) && !eng_busy));

    // R5
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_busy && !en_q) |=> !eng_busy);

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !mdio_oe);
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mgmt_evt;
    logic        mdio_i = 1'b1;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [63:0] got_bits, got_oe;
    int got_rises, min_half, max_half;

    always #10 clk = ~clk;

    mdio_mgmt_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i), .mgmt_evt(mgmt_evt)
    );

    // {raw speed write, PHY response, frame word}
    localparam int NVEC = 5;
    localparam logic [55:0] VEC [NVEC] = '{
        {8'h04, 16'hA5C3, 32'h608A_0000},
        {8'h02, 16'hFFFF, 32'h5192_1234},
        {8'h87, 16'h0001, 32'h6FFE_0000},
        {8'h0A, 16'h0000, 32'h5002_FFFF},
        {8'h02, 16'h8000, 32'h6806_0000}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic watch_frame(input logic [15:0] resp);
        logic prev;
        int gap;
        bit first;
        got_bits = '0; got_oe = '0; got_rises = 0;
        min_half = 1000; max_half = 0;
        prev = mdc; gap = 0; first = 1;
        for (int g = 0; g < 4000; g++) begin
            @(negedge clk);
            gap++;
            if (mdc !== prev) begin
                if (!first) begin
                    if (gap < min_half) min_half = gap;
                    if (gap > max_half) max_half = gap;
                end
                first = 0; gap = 0;
                if (mdc) begin
                    if (got_rises < 64) begin
                        got_bits[63-got_rises] = mdio_o;
                        got_oe[63-got_rises]   = mdio_oe;
                    end
                    got_rises++;
                end else if (got_rises >= 48 && got_rises < 64) begin
                    mdio_i = resp[63-got_rises];
                end
            end
            prev = mdc;
            if (mgmt_evt) break;
        end
        mdio_i = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        logic [31:0] word, prev_word;
        logic [15:0] resp;
        logic [7:0]  spd;
        int          dv;
        bit          rd;
        bit          saw_mdc;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mdc == 0 && mdio_oe == 0 && mgmt_evt == 0, "R1 pins", {mdc, mdio_oe, mgmt_evt}, 0);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), rv);
            chk(rv == 0, "R1 reg", rv, 0);
        end

        wr_reg(2'd0, 32'h1);

        for (int v = 0; v < NVEC; v++) begin
            spd  = VEC[v][55:48];
            resp = VEC[v][47:32];
            word = VEC[v][31:0];
            dv   = int'(spd[6:1]);
            rd   = (word[29:28] == 2'b10);
            wr_reg(2'd1, {24'h0, spd});
            wr_reg(2'd2, word);
            watch_frame(resp);
            // R2 serial content
            chk(got_rises == 64 && got_bits == {32'hFFFF_FFFF, word}, "R2 frame bits", got_bits, {32'hFFFF_FFFF, word});
            // R3 half-period, R7/R10 output enable
            chk(min_half == dv && max_half == dv, "R3 half period", 64'(max_half), 64'(dv));
            if (rd) chk(got_oe == {32'hFFFF_FFFF, 32'hFFFC_0000}, "R7 oe release", got_oe, {32'hFFFF_FFFF, 32'hFFFC_0000});
            else    chk(got_oe == '1, "R10 oe held", got_oe, '1);
            rd_reg(2'd2, rv);
            if (rd) chk(rv == {word[31:16], resp}, "R7 capture", rv, {word[31:16], resp});
            else    chk(rv == word, "R2 data kept", rv, word);
            // R8 / R9 end state
            rd_reg(2'd3, rv);
            chk(rv == 32'h1 && mgmt_evt, "R8 event set busy clear", rv, 1);
            wr_reg(2'd3, 32'h0);
            rd_reg(2'd3, rv);
            chk(rv == 32'h1, "R8 write 0 keeps", rv, 1);
            wr_reg(2'd3, 32'h1);
            rd_reg(2'd3, rv);
            chk(rv == 32'h0 && !mgmt_evt, "R8 w1c clears", rv, 0);
            chk(mdio_oe == 0, "R10 idle oe", mdio_oe, 0);
        end

        // R4 divider zero
        rd_reg(2'd2, rv); prev_word = rv;
        wr_reg(2'd1, 32'h0000_0081);
        wr_reg(2'd2, 32'h5000_0000);
        saw_mdc = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (mdc) saw_mdc = 1;
        end
        chk(!saw_mdc, "R4 mdc low", saw_mdc, 0);
        rd_reg(2'd3, rv);
        chk(rv == 0, "R4 no start", rv, 0);

        // R5 enable clear
        wr_reg(2'd1, 32'h4);
        wr_reg(2'd0, 32'h0);
        wr_reg(2'd2, 32'h6123_0000);
        saw_mdc = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (mdc) saw_mdc = 1;
        end
        rd_reg(2'd3, rv);
        chk(rv == 0 && !saw_mdc, "R5 no start", rv, 0);
        rd_reg(2'd2, rv);
        chk(rv == prev_word, "R5 data unchanged", rv, prev_word);

        // R9 write during busy
        wr_reg(2'd0, 32'h1);
        wr_reg(2'd1, 32'h2);
        word = 32'h5055_AAAA;
        wr_reg(2'd2, word);
        fork
            watch_frame(16'h0);
            begin
                repeat (20) @(negedge clk);
                wr_reg(2'd2, 32'h6FFF_0000);
                rd_reg(2'd3, rv);
                chk(rv == 32'h2, "R9 busy high", rv, 2);
                rd_reg(2'd2, rv);
                chk(rv == word, "R9 data kept in flight", rv, word);
            end
        join
        chk(got_bits == {32'hFFFF_FFFF, word}, "R9 frame unaltered", got_bits, {32'hFFFF_FFFF, word});
        rd_reg(2'd3, rv);
        chk(rv == 32'h1, "R9 busy clear at event", rv, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule